// File: doc/BRIEF.md
# Audio clock ratio monitor

The monitor keeps watch over the master audio clock and the frame (left/right) clock of a serial audio port. The frame clock runs at the sample rate, and the master clock runs at a fixed multiple of it, chosen elsewhere by a two-bit ratio setting. In the master-clock domain the block measures how many master-clock cycles fall between consecutive rising edges of the frame clock. It compares each measurement with the one before it. When the length jumps by more than a set tolerance (32 cycles by default), it emits a one-cycle resynchronization pulse that resets the audio datapaths.

A second detector runs on an independent free-running reference clock. It watches for activity on the master clock and raises a power-down request when none has been seen for a configured time (10 µs by default). A clock-error flag combines both events. It rises on a ratio jump or a stopped clock and stays high until a full frame period has again been measured within tolerance. Acting on the power-down request is left to the surrounding power management.

Top module: `audio_clk_ratio_mon`

## Requirements
- R1: While reset is asserted and immediately after it is released, `resync_o`, `pwrdn_req_o` and `clk_err_o` are all low.
- R2: A frame period is the number of master-clock cycles between two consecutive rising edges of the frame clock, after the frame clock passes through a two-flop synchronizer. When a period differs from the previous one by more than `TOL` cycles, `resync_o` pulses within 4 master-clock cycles of the frame-clock rising edge that closes it.
- R3: A difference of exactly `TOL` cycles (32 by default) produces no resync pulse. A difference of `TOL`+1 cycles produces one.
- R4: After reset, or after a stopped-clock event, the first frame-clock rising edge only starts measurement. The first complete period only loads the reference count. Neither can cause a resync pulse, whatever the measured lengths are.
- R5: `resync_o` is high for exactly one master-clock cycle per detected jump.
- R6: `clk_err_o` rises together with every resync pulse. It stays high until a period is compared within tolerance, and is low after that comparison.
- R7: `pwrdn_req_o` rises once no master-clock activity has reached the reference domain for `REF_CLK_KHZ*STOP_US/1000` reference cycles. It stays low while the master clock runs.
- R8: `pwrdn_req_o` falls once master-clock activity is seen again. `clk_err_o` is high whenever `pwrdn_req_o` is high.
- R9: A stopped-clock event discards the measurement history. `clk_err_o` stays high through the restarting edge and the reloading period. It clears only after a later period compares within tolerance.
- R10: Sequences in which every period differs from its predecessor by at most `TOL` cycles never produce a resync pulse and keep `clk_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master audio clock |
| lrck_i | input | 1 | Frame (left/right) clock, asynchronous to mclk_i |
| ref_clk_i | input | 1 | Free-running reference clock for stop detection |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| resync_o | output | 1 | One-cycle datapath resynchronization pulse (mclk domain) |
| pwrdn_req_o | output | 1 | Power-down request on a stopped master clock (reference domain) |
| clk_err_o | output | 1 | Clock error flag: ratio jump or stopped clock |

## Verification
The bench builds the block with a 125 MHz reference clock (`REF_CLK_KHZ=125000`) and `STOP_US=2`, giving a stop limit of 250 reference cycles. A stopped clock can therefore be checked on both sides of the limit within a short run. `TOL` stays at 32 and `CNT_W` at 12, so frame lengths of 128 to 512 cycles reach the exact 32/33 boundary as well as random jumps and in-tolerance jitter. `TOG_DIV_LOG2=2` keeps the master-clock activity toggle slow enough for the reference clock to sample it reliably at a 50 MHz master clock.

// File: rtl/acrm_pkg.sv
package acrm_pkg;

  // absolute difference of two cycle counts
  function automatic int unsigned cnt_delta(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // true when two periods are further apart than the tolerance
  function automatic logic beyond_tol(input int unsigned a, input int unsigned b,
                                      input int unsigned tol);
    return cnt_delta(a, b) > tol;
  endfunction

  // reference cycles corresponding to the stop interval
  function automatic int unsigned stop_cycles(input int unsigned khz, input int unsigned us);
    return (khz * us) / 1000;
  endfunction

endpackage

// File: rtl/acrm_sync.sv
module acrm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/acrm_period_cmp.sv
module acrm_period_cmp #(
  parameter int CNT_W = 12,
  parameter int TOL   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic flush_i,
  output logic resync_o,
  output logic err_o,
  output logic ref_valid_o
);
  import acrm_pkg::*;

  logic [CNT_W-1:0] cnt_q, ref_q;
  logic armed_q, ref_valid_q, err_q, resync_q;
  logic jump;

  assign jump = beyond_tol(32'(cnt_q), 32'(ref_q), TOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      ref_q       <= '0;
      armed_q     <= 1'b0;
      ref_valid_q <= 1'b0;
      err_q       <= 1'b0;
      resync_q    <= 1'b0;
    end else begin
      resync_q <= 1'b0;
      if (flush_i) begin
        cnt_q       <= '0;
        armed_q     <= 1'b0;
        ref_valid_q <= 1'b0;
        err_q       <= 1'b1;
      end else if (edge_i) begin
        cnt_q <= CNT_W'(1);
        if (!armed_q) begin
          armed_q <= 1'b1;
        end else if (!ref_valid_q) begin
          ref_q       <= cnt_q;
          ref_valid_q <= 1'b1;
        end else begin
          ref_q    <= cnt_q;
          resync_q <= jump;
          err_q    <= jump;
        end
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign resync_o    = resync_q;
  assign err_o       = err_q;
  assign ref_valid_o = ref_valid_q;
endmodule

// File: rtl/acrm_stop_det.sv
module acrm_stop_det #(
  parameter int LIMIT    = 240,
  parameter int DIV_LOG2 = 3
) (
  input  logic mclk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic seen_o,
  output logic pwrdn_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [DIV_LOG2-1:0] div_q;
  logic tog_s, tog_d;
  logic [CW-1:0] idle_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + DIV_LOG2'(1);
  end

  acrm_sync #(.STAGES(2)) tog_sync_i (
    .clk(ref_clk), .rst_n(rst_n), .d(div_q[DIV_LOG2-1]), .q(tog_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d  <= 1'b0;
      idle_q <= '0;
    end else begin
      tog_d <= tog_s;
      if (tog_s ^ tog_d)               idle_q <= '0;
      else if (idle_q != CW'(LIMIT))   idle_q <= idle_q + CW'(1);
    end
  end

  assign seen_o  = tog_s ^ tog_d;
  assign pwrdn_o = (idle_q == CW'(LIMIT));
endmodule

// File: rtl/audio_clk_ratio_mon.sv
module audio_clk_ratio_mon #(
  parameter int CNT_W        = 12,
  parameter int TOL          = 32,
  parameter int REF_CLK_KHZ  = 24000,
  parameter int STOP_US      = 10,
  parameter int TOG_DIV_LOG2 = 3
) (
  input  logic mclk_i,
  input  logic lrck_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic resync_o,
  output logic pwrdn_req_o,
  output logic clk_err_o
);
  import acrm_pkg::*;

  localparam int STOP_LIMIT = stop_cycles(REF_CLK_KHZ, STOP_US);

  logic lr_s, lr_d, lr_rise;
  logic stop_in_mclk, mclk_seen, ref_valid, ratio_err, pwrdn;

  acrm_sync #(.STAGES(2)) lr_sync_i (
    .clk(mclk_i), .rst_n(rst_ni), .d(lrck_i), .q(lr_s)
  );

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) lr_d <= 1'b0;
    else         lr_d <= lr_s;
  end

  assign lr_rise = lr_s & ~lr_d;

  acrm_stop_det #(.LIMIT(STOP_LIMIT), .DIV_LOG2(TOG_DIV_LOG2)) stop_i (
    .mclk(mclk_i), .ref_clk(ref_clk_i), .rst_n(rst_ni),
    .seen_o(mclk_seen), .pwrdn_o(pwrdn)
  );

  acrm_sync #(.STAGES(2)) stop_sync_i (
    .clk(mclk_i), .rst_n(rst_ni), .d(pwrdn), .q(stop_in_mclk)
  );

  acrm_period_cmp #(.CNT_W(CNT_W), .TOL(TOL)) cmp_i (
    .clk(mclk_i), .rst_n(rst_ni), .edge_i(lr_rise), .flush_i(stop_in_mclk),
    .resync_o(resync_o), .err_o(ratio_err), .ref_valid_o(ref_valid)
  );

  assign pwrdn_req_o = pwrdn;
  assign clk_err_o   = ratio_err | pwrdn;
endmodule

// File: rtl/acrm_checker.sv
module acrm_checker (
  input logic mclk,
  input logic ref_clk,
  input logic rst_n,
  input logic resync,
  input logic clk_err,
  input logic pwrdn,
  input logic lr_rise,
  input logic ref_valid,
  input logic mclk_seen
);
  // R5
  resync_one_cycle_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    resync |=> !resync);

  // R6
  resync_sets_err_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    resync |-> clk_err);

  // R2
  resync_after_edge_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    resync |-> $past(lr_rise));

  // R4
  resync_needs_ref_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    resync |-> $past(ref_valid));

  // R8
  pwrdn_drops_on_activity_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mclk_seen |=> !pwrdn);
endmodule

bind audio_clk_ratio_mon acrm_checker chk_i (
  .mclk(mclk_i), .ref_clk(ref_clk_i), .rst_n(rst_ni),
  .resync(resync_o), .clk_err(clk_err_o), .pwrdn(pwrdn_req_o),
  .lr_rise(lr_rise), .ref_valid(ref_valid), .mclk_seen(mclk_seen)
);

// File: tb/audio_clk_ratio_mon_tb_top.sv
`timescale 1ns/1ps
module audio_clk_ratio_mon_tb_top;
  localparam int TOLB = 32;

  logic mclk = 0, ref_clk = 0, lrck = 0, rst_n = 0, mclk_en = 1;
  logic resync, pwrdn, clk_err;
  int checks = 0, fails = 0, mon_rs = 0, exp_rs = 0;
  bit exp_err = 0, m_arm = 0, m_ref_ok = 0, done = 0;
  int m_ref = 0, m_cur = 0;

  always #4 ref_clk = ~ref_clk;
  always begin #10; if (mclk_en) mclk = ~mclk; end

  audio_clk_ratio_mon #(.CNT_W(12), .TOL(TOLB), .REF_CLK_KHZ(125000), .STOP_US(2),
                        .TOG_DIV_LOG2(2)) dut_i (
    .mclk_i(mclk), .lrck_i(lrck), .ref_clk_i(ref_clk), .rst_ni(rst_n),
    .resync_o(resync), .pwrdn_req_o(pwrdn), .clk_err_o(clk_err));

  always @(negedge mclk) if (resync) mon_rs++;

  function automatic int diff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic frame(input int p);
    string tag;
    tag = "R10";
    if (!m_arm) begin
      m_arm = 1; tag = "R4";
    end else if (!m_ref_ok) begin
      m_ref = m_cur; m_ref_ok = 1; tag = "R4";
    end else begin
      if (diff(m_cur, m_ref) > TOLB) begin exp_rs++; exp_err = 1; tag = "R2"; end
      else begin
        if (exp_err) tag = "R6";
        exp_err = 0;
      end
      if (diff(m_cur, m_ref) == TOLB || diff(m_cur, m_ref) == TOLB + 1) tag = "R3";
      m_ref = m_cur;
    end
    m_cur = p;
    lrck = 1;
    repeat (p / 2) @(negedge mclk);
    lrck = 0;
    repeat (p - p / 2) @(negedge mclk);
    chk(mon_rs == exp_rs, tag, mon_rs, exp_rs);
    chk(clk_err == exp_err, tag, clk_err, exp_err);
  endtask

  initial begin
    int p;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge mclk);
    chk(resync == 0 && pwrdn == 0 && clk_err == 0, "R1", {resync, pwrdn, clk_err}, 0);
    rst_n = 1;
    repeat (3) @(negedge mclk);
    chk(resync == 0 && pwrdn == 0 && clk_err == 0, "R1", {resync, pwrdn, clk_err}, 0);
    repeat (500) @(negedge mclk);       // long partial period before the first edge
    // R4: arm, then load; R2 jump; R3 boundaries; R6 clear
    frame(256); frame(140); frame(256); frame(256);
    frame(288); frame(321); frame(321); frame(321);
    // random: in-tolerance jitter with occasional jumps
    p = 321;
    for (int i = 0; i < 120; i++) begin
      int d;
      if ($urandom_range(4, 0) == 0) d = int'($urandom_range(96, 33));
      else d = int'($urandom_range(TOLB, 0));
      if ($urandom_range(1, 0) == 1) d = -d;
      p = p + d;
      if (p < 128) p = 128 + diff(p, 128);
      if (p > 512) p = 512 - diff(p, 512);
      frame(p);
    end
    // R7: stop the master clock
    @(negedge mclk); mclk_en = 0;
    repeat (200) @(negedge ref_clk);
    chk(pwrdn == 0, "R7", pwrdn, 0);
    repeat (100) @(negedge ref_clk);
    chk(pwrdn == 1, "R7", pwrdn, 1);
    chk(clk_err == 1, "R8", clk_err, 1);
    chk(mon_rs == exp_rs, "R7", mon_rs, exp_rs);
    mclk_en = 1;
    repeat (40) @(negedge mclk);
    chk(pwrdn == 0, "R8", pwrdn, 0);
    m_arm = 0; m_ref_ok = 0; exp_err = 1;
    chk(clk_err == 1, "R9", clk_err, 1);
    frame(256); frame(400); frame(410); frame(412);
    chk(clk_err == 0, "R9", clk_err, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule